// File: doc/BRIEF.md
# Watchdog Clock Source Switch

This block picks the clock that drives a watchdog counter. It chooses between the peripheral clock and a free-running low-speed oscillator clock. Software writes a one-bit source choice into a shadow input at any time. That value does nothing until the watchdog feed sequence reports completion with a one-cycle pulse. Only then is the shadow value taken as the requested source.

The switch is break-before-make. The enable of the current clock is withdrawn first, in that clock's own domain. The release is then seen through a two-stage synchronizer in the other domain, and only after that does the other clock's enable rise. Each enable changes only while its own clock is low, so the gated output never carries a shortened pulse. If the current clock halts before it has let go, the new clock is never admitted and the output stays frozen.

A status bit in the peripheral clock domain reports which source drives the output. While a switch is still running, further feed pulses are not used to change the selection.

Top module: `wdclk_switch`

## Requirements
- R1: After reset the peripheral clock drives the output immediately and the status output reads 0. No handshake is needed to reach this state.
- R2: The select encoding is 0 for the peripheral clock and 1 for the oscillator clock. Changing the shadow select without a feed pulse leaves the status and the clock driving the output unchanged.
- R3: A feed pulse samples the shadow select. Once the switch completes, the status output equals that value and the output toggles at the chosen clock's rate.
- R4: The two clock enables are never active at the same moment. No high or low phase of the output is shorter than the shorter half-period of the two input clocks.
- R5: After the feed pulse, the status reflects the new source within 20 peripheral clock cycles, for an oscillator at least a third as fast as the peripheral clock.
- R6: A feed pulse that arrives while a switch is still in progress does not alter the requested source. The switch in progress completes to its original target.
- R7: If the old clock stops before its enable has been withdrawn, the new clock is never admitted and the output makes no edges. When the old clock runs again, the switch completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Peripheral clock |
| pclkRstN | input | 1 | Active-low asynchronous reset, peripheral domain |
| oscClk | input | 1 | Low-speed oscillator clock |
| oscRstN | input | 1 | Active-low asynchronous reset, oscillator domain |
| selShadow | input | 1 | Software-written source choice (0 peripheral, 1 oscillator) |
| feedDone | input | 1 | One-cycle pulse in the peripheral domain marking a completed feed |
| wdClk | output | 1 | Gated clock for the watchdog counter |
| srcIsOsc | output | 1 | Current source status, peripheral domain (1 = oscillator) |

## Verification
The requested source is registered on the first peripheral edge that sees the feed pulse. Status then settles after the old clock's withdrawal, two oscillator synchronizer edges, an enable flop and two more peripheral synchronizer edges. The bench therefore polls status a few nanoseconds after each peripheral edge and counts the edges until it matches, holding the count to the R5 bound. Output-rate checks begin only once status has settled, plus two further peripheral cycles, so that the final enable flop has also switched. They count output rising edges over a fixed 800 ns window, a figure that separates the two source rates clearly. Pulse widths are tracked for the whole run and judged once at the end.

// File: rtl/wdcs_pkg.sv
`timescale 1ns/1ps
package wdcs_pkg;
  localparam logic SRC_PCLK = 1'b0;
  localparam logic SRC_OSC  = 1'b1;

  // strobes from control (peripheral domain) to datapath
  typedef struct packed {
    logic reqOsc;  // requested source, 1 = oscillator
    logic pclkGo;  // next value for the peripheral clock enable
  } wdcsCtl_t;
endpackage

// File: rtl/wdcs_sync.sv
`timescale 1ns/1ps
module wdcs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RST_VAL;
        else       chain <= d;
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          chain <= {STAGES{RST_VAL}};
        end else begin
          chain[0] <= d;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wdcs_ctrl.sv
`timescale 1ns/1ps
module wdcs_ctrl
  import wdcs_pkg::*;
(
  input  logic     pclk,
  input  logic     rstN,
  input  logic     selShadow,
  input  logic     feedDone,
  input  logic     oscSeen,   // oscillator enable as seen in peripheral domain
  input  logic     pclkEn,    // current peripheral clock enable
  output wdcsCtl_t ctl
);
  logic reqOsc;
  logic settled;
  logic busy;

  // a switch is finished once the target enable owns the output alone
  always_comb begin
    if (reqOsc == SRC_OSC) settled = oscSeen && !pclkEn;
    else                   settled = pclkEn && !oscSeen;
    busy = !settled;
  end

  always_ff @(posedge pclk or negedge rstN) begin
    if (!rstN)                  reqOsc <= SRC_PCLK;
    else if (feedDone && !busy) reqOsc <= selShadow;
  end

  always_comb begin
    ctl.reqOsc = reqOsc;
    ctl.pclkGo = (reqOsc == SRC_PCLK) && !oscSeen;
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge pclk) disable iff (!rstN)
    busy |=> $stable(reqOsc)); // R6
  AST_NO_FEED_NO_CHANGE: assert property (@(posedge pclk) disable iff (!rstN)
    !feedDone |=> $stable(reqOsc)); // R2
  AST_STATUS_EXCL: assert property (@(posedge pclk) disable iff (!rstN)
    oscSeen |-> !pclkEn); // R4
endmodule

// File: rtl/wdcs_path.sv
`timescale 1ns/1ps
module wdcs_path
  import wdcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     pclk,
  input  logic     pclkRstN,
  input  logic     oscClk,
  input  logic     oscRstN,
  input  wdcsCtl_t ctl,
  output logic     oscSeen,
  output logic     pclkEn,
  output logic     wdClk
);
  logic oscEn;
  logic reqInOsc;
  logic pclkSeen;

  // oscillator enable brought into the peripheral domain
  wdcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uOscToP (
    .clk(pclk), .rstN(pclkRstN), .d(oscEn), .q(oscSeen));

  // request and peripheral enable brought into the oscillator domain
  wdcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) uReqToO (
    .clk(oscClk), .rstN(oscRstN), .d(ctl.reqOsc), .q(reqInOsc));
  wdcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uPToO (
    .clk(oscClk), .rstN(oscRstN), .d(pclkEn), .q(pclkSeen));

  // enables change only while their own clock is low
  always_ff @(negedge pclk or negedge pclkRstN) begin
    if (!pclkRstN) pclkEn <= 1'b1;
    else           pclkEn <= ctl.pclkGo;
  end

  always_ff @(negedge oscClk or negedge oscRstN) begin
    if (!oscRstN) oscEn <= 1'b0;
    else          oscEn <= reqInOsc && !pclkSeen;
  end

  assign wdClk = (pclk & pclkEn) | (oscClk & oscEn);

  AST_EN_EXCL_PCLK: assert property (@(posedge pclk)
    disable iff (!pclkRstN || !oscRstN) !(pclkEn && oscEn)); // R4
  AST_EN_EXCL_OSC: assert property (@(posedge oscClk)
    disable iff (!pclkRstN || !oscRstN) !(pclkEn && oscEn)); // R4
  AST_OSC_NEEDS_REQ: assert property (@(posedge oscClk)
    disable iff (!pclkRstN || !oscRstN) $rose(oscEn) |-> reqInOsc); // R3
endmodule

// File: rtl/wdclk_switch.sv
`timescale 1ns/1ps
module wdclk_switch
  import wdcs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic pclk,
  input  logic pclkRstN,
  input  logic oscClk,
  input  logic oscRstN,
  input  logic selShadow,
  input  logic feedDone,
  output logic wdClk,
  output logic srcIsOsc
);
  wdcsCtl_t ctl;
  logic     oscSeen;
  logic     pclkEn;

  wdcs_ctrl uCtrl (
    .pclk(pclk), .rstN(pclkRstN), .selShadow(selShadow), .feedDone(feedDone),
    .oscSeen(oscSeen), .pclkEn(pclkEn), .ctl(ctl));

  wdcs_path #(.SYNC_STAGES(SYNC_STAGES)) uPath (
    .pclk(pclk), .pclkRstN(pclkRstN), .oscClk(oscClk), .oscRstN(oscRstN),
    .ctl(ctl), .oscSeen(oscSeen), .pclkEn(pclkEn), .wdClk(wdClk));

  assign srcIsOsc = oscSeen;
endmodule

// File: tb/wdclk_switch_tb.sv
`timescale 1ns/1ps
module wdclk_switch_tb;
  logic pclk = 0, oscClk = 0, pclkRun = 1;
  logic pclkRstN = 0, oscRstN = 0, selShadow = 0, feedDone = 0;
  wire  wdClk, srcIsOsc;
  int   checks = 0, errors = 0, wdEdges = 0;
  bit   finished = 0, seenRise = 0, seenFall = 0;
  realtime lastRise = 0, lastFall = 0, minHigh = 1e9, minLow = 1e9;

  wdclk_switch u_dut (
    .pclk(pclk), .pclkRstN(pclkRstN), .oscClk(oscClk), .oscRstN(oscRstN),
    .selShadow(selShadow), .feedDone(feedDone), .wdClk(wdClk), .srcIsOsc(srcIsOsc));

  always begin #10; if (pclkRun) pclk = ~pclk; end  // 50 MHz, can halt
  always #33 oscClk = ~oscClk;

  always @(posedge wdClk) begin
    wdEdges++;
    if (seenFall && ($realtime - lastFall) < minLow) minLow = $realtime - lastFall;
    lastRise = $realtime; seenRise = 1;
  end
  always @(negedge wdClk) begin
    if (seenRise && ($realtime - lastRise) < minHigh) minHigh = $realtime - lastRise;
    lastFall = $realtime; seenFall = 1;
  end

  task automatic check(string req, bit ok, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(logic v);
    @(negedge pclk); selShadow = v; feedDone = 1;
    @(negedge pclk); feedDone = 0;
  endtask

  task automatic waitStatus(logic v, output int cyc);
    cyc = 0;
    while (srcIsOsc !== v && cyc < 40) begin @(posedge pclk); #5; cyc++; end
  endtask

  task automatic countEdges(output int n);
    wdEdges = 0; #800; n = wdEdges;
  endtask

  task automatic rateCheck(string req, logic osc);
    int n;
    countEdges(n);
    if (osc) check(req, n >= 11 && n <= 13, n, 12);
    else     check(req, n >= 39 && n <= 41, n, 40);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    #55 pclkRstN = 1; oscRstN = 1;
    repeat (3) @(posedge pclk); #5;
    check("R1 status after reset", srcIsOsc === 1'b0, srcIsOsc, 0);
    rateCheck("R1 pclk drives output after reset", 1'b0);

    // sweep: current source x shadow value x feed or not
    for (int cur = 0; cur < 2; cur++)
      for (int nv = 0; nv < 2; nv++)
        for (int f = 0; f < 2; f++) begin
          logic expv;
          feed(cur[0]); waitStatus(cur[0], cyc);
          repeat (4) @(posedge pclk);
          if (f) feed(nv[0]);
          else begin @(negedge pclk); selShadow = nv[0]; repeat (2) @(negedge pclk); end
          expv = f ? nv[0] : cur[0];
          if (f && nv != cur) begin
            waitStatus(expv, cyc);
            check("R5 switch latency", cyc <= 20, cyc, 20);
          end
          repeat (25) @(posedge pclk); #5;
          if (f) check("R3 status follows fed value", srcIsOsc === expv, srcIsOsc, expv);
          else   check("R2 shadow write alone ignored", srcIsOsc === expv, srcIsOsc, expv);
          rateCheck(f ? "R3 output rate" : "R2 output rate unchanged", expv);
        end

    // R6: second feed during a switch
    feed(1'b0); waitStatus(1'b0, cyc); repeat (4) @(posedge pclk);
    feed(1'b1); feed(1'b0);
    waitStatus(1'b1, cyc); repeat (30) @(posedge pclk); #5;
    check("R6 feed during switch ignored", srcIsOsc === 1'b1, srcIsOsc, 1);
    rateCheck("R6 output stays on oscillator", 1'b1);

    // R7: halt the old clock before it releases
    feed(1'b0); waitStatus(1'b0, cyc); repeat (4) @(posedge pclk);
    @(negedge pclk); selShadow = 1; feedDone = 1;
    @(posedge pclk); #2 pclkRun = 0; feedDone = 0;
    wdEdges = 0; #1000;
    check("R7 no output edges while old clock halted", wdEdges == 0, wdEdges, 0);
    check("R7 output frozen", wdClk === 1'b1, wdClk, 1);
    pclkRun = 1;
    waitStatus(1'b1, cyc); repeat (4) @(posedge pclk); #5;
    check("R7 switch completes after resume", srcIsOsc === 1'b1, srcIsOsc, 1);
    rateCheck("R7 oscillator drives after resume", 1'b1);

    check("R4 minimum high phase ns", minHigh >= 9.0, $rtoi(minHigh), 10);
    check("R4 minimum low phase ns", minLow >= 9.0, $rtoi(minLow), 10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule